// File: doc/BRIEF.md
# Way-Predicting Two-Way Read Cache

This block is a two-way set-associative read cache that avoids reading both ways on every access. A small prediction table holds one bit per set naming the way to try first. Only that way's tag is compared in the cycle a request is accepted. On a match the data comes back one cycle later, and the response is flagged as fast.

When the predicted way does not match, the other way is compared in the following cycle. A match there is a slow hit, and it rewrites the prediction bit for that set. When neither way matches, the block issues a line request on its refill port. It installs the returned line in the way chosen by a per-set LRU bit and points the prediction at that way. It then forwards the line to the processor.

The processor side is a valid/ready read port with a single-cycle response pulse. The refill side is a request/response pair. Only one access is in flight at a time.

Top module: `wp_cache`

## Requirements
- R1: After reset, req_ready is 1, resp_valid and mem_req_valid are 0, every line is invalid and every prediction bit selects way 0, so the first read of any address misses.
- R2: The prediction bit is selected by the set index, which is the low IDX_W bits of req_addr. When the predicted way holds the address, resp_valid is 1 in the cycle after acceptance, with resp_fast=1, resp_slow=0 and the stored line on resp_data.
- R3: When the predicted way misses and the other way holds the address, resp_valid is 1 two cycles after acceptance, with resp_slow=1, resp_fast=0 and the stored line.
- R4: A slow hit sets the set's prediction bit to the way that hit, so an immediate repeat of that read is a fast hit.
- R5: When both ways miss, mem_req_valid rises two cycles after acceptance with mem_req_addr equal to the request address. Both are held unchanged until mem_req_ready is 1.
- R6: In the cycle after mem_resp_valid is 1, resp_valid is 1 with resp_fast=0 and resp_slow=0, and resp_data equals the refill data. The line is then resident.
- R7: After a refill, the set's prediction bit names the way that received the line, so the next read of that line is a fast hit.
- R8: The refill victim is the way named by the set's LRU bit. Every hit and every refill points that bit at the other way, so the most recently used line survives the next miss in its set.
- R9: req_ready is 0 while a second-way probe or a refill is in progress. After a fast hit it stays 1, so reads can be accepted on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor read request present |
| req_ready | output | 1 | Cache can accept a request |
| req_addr | input | ADDR_W | Line address of the read |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_data | output | DATA_W | Line data returned |
| resp_fast | output | 1 | Response came from the predicted way |
| resp_slow | output | 1 | Response came from the other way |
| mem_req_valid | output | 1 | Refill request to the next level |
| mem_req_ready | input | 1 | Next level accepts the refill request |
| mem_req_addr | output | ADDR_W | Line address to refill |
| mem_resp_valid | input | 1 | Refill data present |
| mem_resp_data | input | DATA_W | Refill line data |

## Verification
Counting the acceptance edge as cycle 0, a fast hit's response is due at cycle 1, a slow hit's at cycle 2 and the refill request at cycle 2. A miss's response is due one cycle after the refill data is presented. The bench drives inputs and samples outputs on falling edges, and it counts cycles from acceptance. Each response is compared against the cycle number and the hit kind its requirement predicts. The bench also checks that req_ready is low in the first cycle of every slow or missing access, and that the refill request appears at exactly its cycle with the right address.

// File: rtl/wp_cache.sv
module wp_cache #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_data,
  output logic              resp_fast,
  output logic              resp_slow,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_resp_valid,
  input  logic [DATA_W-1:0] mem_resp_data
);
  localparam int SETS  = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  typedef enum logic [1:0] {S_IDLE, S_ALT, S_MREQ, S_MWAIT} state_t;
  state_t state;

  logic [TAG_W-1:0]  tags  [2][SETS];
  logic [DATA_W-1:0] lines [2][SETS];
  logic [SETS-1:0]   vld   [2];
  logic [SETS-1:0]   pred;
  logic [SETS-1:0]   lru;

  logic [ADDR_W-1:0] addr_q;
  logic              pw_q;

  wire              accept = req_valid && req_ready;
  wire [IDX_W-1:0]  idx_in = req_addr[IDX_W-1:0];
  wire [TAG_W-1:0]  tag_in = req_addr[ADDR_W-1:IDX_W];
  wire              pw_in  = pred[idx_in];
  wire              fast_hit = vld[pw_in][idx_in] && (tags[pw_in][idx_in] == tag_in);

  wire [IDX_W-1:0]  idx_q  = addr_q[IDX_W-1:0];
  wire [TAG_W-1:0]  tag_qr = addr_q[ADDR_W-1:IDX_W];
  wire              alt_w  = ~pw_q;
  wire              alt_hit = vld[alt_w][idx_q] && (tags[alt_w][idx_q] == tag_qr);
  wire              victim = lru[idx_q];
  wire              fill   = (state == S_MWAIT) && mem_resp_valid;

  assign req_ready     = (state == S_IDLE);
  assign mem_req_valid = (state == S_MREQ);
  assign mem_req_addr  = addr_q;

  always_ff @(posedge clk) begin
    if (fill) begin
      tags[victim][idx_q]  <= tag_qr;
      lines[victim][idx_q] <= mem_resp_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      vld[0]     <= '0;
      vld[1]     <= '0;
      pred       <= '0;
      lru        <= '0;
      addr_q     <= '0;
      pw_q       <= 1'b0;
      resp_valid <= 1'b0;
      resp_fast  <= 1'b0;
      resp_slow  <= 1'b0;
      resp_data  <= '0;
    end else begin
      resp_valid <= 1'b0;
      resp_fast  <= 1'b0;
      resp_slow  <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          addr_q <= req_addr;
          pw_q   <= pw_in;
          if (fast_hit) begin
            resp_valid  <= 1'b1;
            resp_fast   <= 1'b1;
            resp_data   <= lines[pw_in][idx_in];
            lru[idx_in] <= ~pw_in;
          end else begin
            state <= S_ALT;
          end
        end
        S_ALT: if (alt_hit) begin
          resp_valid <= 1'b1;
          resp_slow  <= 1'b1;
          resp_data  <= lines[alt_w][idx_q];
          pred[idx_q] <= alt_w;
          lru[idx_q]  <= ~alt_w;
          state <= S_IDLE;
        end else begin
          state <= S_MREQ;
        end
        S_MREQ: if (mem_req_ready) state <= S_MWAIT;
        S_MWAIT: if (mem_resp_valid) begin
          vld[victim][idx_q] <= 1'b1;
          pred[idx_q] <= victim;
          lru[idx_q]  <= ~victim;
          resp_valid  <= 1'b1;
          resp_data   <= mem_resp_data;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  wire pred_at_q = pred[idx_q];
  wire lru_at_q  = lru[idx_q];

  p_fast_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fast) |-> $past(accept));

  p_slow_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_slow) |-> ($past(state == S_ALT) && !resp_fast));

  p_retrain_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_slow) |-> (pred_at_q != $past(pred_at_q)));

  p_memreq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  p_fill_resp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_fast && !resp_slow) |-> ($past(mem_resp_valid) && resp_data == $past(mem_resp_data)));

  p_fill_pred_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_fast && !resp_slow) |-> (pred_at_q == $past(lru_at_q)));

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(accept) && !resp_valid) |-> !req_ready);

  p_kind_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_fast || resp_slow) |-> resp_valid);
endmodule

// File: tb/wp_cache_tb.sv
module wp_cache_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [11:0] req_addr = '0;
  logic        resp_valid;
  logic [31:0] resp_data;
  logic        resp_fast, resp_slow;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [11:0] mem_req_addr;
  logic        mem_resp_valid = 1'b0;
  logic [31:0] mem_resp_data = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wp_cache #(.ADDR_W(12), .DATA_W(32), .IDX_W(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .resp_valid(resp_valid), .resp_data(resp_data),
    .resp_fast(resp_fast), .resp_slow(resp_slow), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data));

  function automatic logic [31:0] mdata(input logic [11:0] a);
    return {a, ~a, 8'h3C};
  endfunction

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  localparam int K_FAST = 0, K_SLOW = 1, K_MISS = 2;

  task automatic rd(input logic [11:0] a, input int kind, input string rq);
    int cyc;
    bit got, seen;
    @(negedge clk);
    chk(req_ready, {rq, " ready before request"}, req_ready, 1);
    req_valid = 1'b1;
    req_addr  = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1; got = 0; seen = 0;
    while (!got && cyc < 30) begin
      if (resp_valid) begin
        got = 1;
        chk(cyc == (kind == K_FAST ? 1 : kind == K_SLOW ? 2 : 4), {rq, " latency"}, cyc,
            kind == K_FAST ? 1 : kind == K_SLOW ? 2 : 4);
        chk(resp_fast == (kind == K_FAST), {rq, " fast flag"}, resp_fast, kind == K_FAST);
        chk(resp_slow == (kind == K_SLOW), {rq, " slow flag"}, resp_slow, kind == K_SLOW);
        chk(resp_data == mdata(a), {rq, " data"}, resp_data, mdata(a));
      end else begin
        if (cyc == 1) chk(!req_ready, "R9 stall during non-fast access", req_ready, 0);
        if (mem_req_valid && !seen) begin
          seen = 1;
          chk(kind == K_MISS, {rq, " unexpected refill"}, 1, 0);
          chk(cyc == 2, "R5 refill request cycle", cyc, 2);
          chk(mem_req_addr == a, "R5 refill address", mem_req_addr, a);
          mem_req_ready = 1'b1;
          @(negedge clk);
          mem_req_ready  = 1'b0;
          mem_resp_valid = 1'b1;
          mem_resp_data  = mdata(a);
          @(negedge clk);
          mem_resp_valid = 1'b0;
          cyc += 2;
        end else begin
          @(negedge clk);
          cyc++;
        end
      end
    end
    chk(got, {rq, " response seen"}, got, 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(resp_valid == 1'b0, "R1 no response after reset", resp_valid, 0);
    chk(mem_req_valid == 1'b0, "R1 no refill after reset", mem_req_valid, 0);
  endtask

  task automatic t_back_to_back(input logic [11:0] a);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    @(posedge clk);
    @(negedge clk);
    chk(resp_valid && resp_fast, "R9 first back-to-back fast hit", resp_valid, 1);
    chk(req_ready, "R9 ready held after fast hit", req_ready, 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(resp_valid && resp_fast, "R9 second back-to-back fast hit", resp_valid, 1);
    chk(resp_data == mdata(a), "R9 back-to-back data", resp_data, mdata(a));
  endtask

  localparam logic [11:0] A = 12'h0A1, B = 12'h151, C = 12'h2E9, D = 12'h0A2;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    rd(A, K_MISS, "R1 R6 first read of A misses");
    rd(A, K_FAST, "R7 R2 A after refill");
    rd(B, K_MISS, "R6 B conflicts in same set");
    rd(B, K_FAST, "R7 B after refill");
    rd(A, K_SLOW, "R3 A in unpredicted way");
    rd(A, K_FAST, "R4 A after retrain");
    rd(C, K_MISS, "R8 C evicts B");
    rd(A, K_SLOW, "R3 A survives C refill");
    rd(B, K_MISS, "R8 B evicted earlier");
    rd(A, K_SLOW, "R8 A survives as most recent");
    rd(C, K_MISS, "R8 C evicted by B");
    rd(D, K_MISS, "R6 other set refill");
    t_back_to_back(D);
    done = 1'b1;
  end

  always @(posedge clk) begin
    cycles++;
    if (done || cycles > 20000) begin
      if (!done) begin
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule